// File: doc/BRIEF.md
# Clock-Synchronous Serial Master

This block is a master-only synchronous serial port. It drives a shift clock that idles high. It shifts a word of 8 to 16 bits out on a data line and, in the same frame, shifts a word in from a second data line. A host reaches it through a small register bus with a two-bit address. Through that bus it sets the mode enables and the frame length, loads transmit data, reads status flags and fetches received words.

Three modes come from two enable bits. Transmit-only sends each word that the host loads and runs frames back to back while new data keeps arriving. Receive-only clocks frames in without a break for as long as it is enabled and no overrun is pending. Full-duplex starts a frame on each transmit-data write and stops at the end of a frame when no further word is waiting or when an overrun has occurred. A software-reset bit returns the sequencer and shift register to idle and leaves the data registers and flags as they are. Clearing the enables in the right order lets the host leave duplex mode without a stray clock pulse.

Top module: `sync_serial_master`

## Requirements
- R1: After reset, the status word (address 2 read; bit0 transmit-empty, bit1 transmit-end, bit2 receive-full, bit3 overrun) reads 0x3. The control word (address 0; bit0 transmit enable, bit1 receive enable, bit2 software reset) reads 0. The length field reads 7. The clock and data outputs are high.
- R2: Address 1 bits [3:0] hold the frame length minus one. Written values below 7 read back as 7. Each frame gives exactly that many clock pulses, and the length is taken when a frame starts.
- R3: Data goes MSB first. The clock idles high. The output bit changes with each falling clock edge, and the input is sampled at the rising edge. Each clock phase lasts HALF_DIV system cycles.
- R4: A write to address 2 loads the transmit word and clears transmit-empty and transmit-end. Moving a word into the shift register sets transmit-empty again.
- R5: In a transmit mode, a frame that ends with transmit-empty set raises transmit-end. If a new word is waiting instead, the next frame follows without host action.
- R6: With receive enabled, a frame that ends while receive-full is 0 stores the received bits, right-aligned, readable at address 3, and sets receive-full. A read of address 3 with the read strobe clears receive-full.
- R7: A frame that ends while receive-full is 1 sets overrun and discards the new word, so address 3 keeps its old value. Writing address 3 with bit0 = 1 clears overrun.
- R8: In duplex mode only a transmit-data write starts a frame. The unit halts at the end of a frame when transmit-empty is 1 or overrun is 1, even if a word is waiting.
- R9: In receive-only mode, frames follow one another while the receive enable stays 1 and overrun stays 0.
- R10: From idle duplex mode, clearing receive enable before transmit enable, or clearing both together, gives no clock pulse. Clearing transmit enable while receive enable stays 1 starts receive clocking.
- R11: While the software-reset bit is 1, the sequencer is idle with the clock high, even mid-frame. The transmit and receive data registers, the flags, the length and the enables keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect at address 3 only) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address |
| sck_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |

## Verification
The hardest state to reach is a duplex halt caused by overrun while a further transmit word is already waiting. To get there, the host must leave one received word unread and start a frame, then load a second word after the first has moved into the shift register but before the frame ends. The bench polls transmit-empty to find that window. A serial slave model in the bench loops the output back through a shift register, so the words sent and received can both be compared with values set up in advance. Clock pulses are counted on the sck line to show the halt and the absence of stray clocks.

// File: rtl/sync_serial_master.sv
module sync_serial_master #(
  parameter int DATA_W   = 16,
  parameter int MIN_LEN  = 8,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sck_o,
  output logic              sdo_o,
  input  logic              sdi_i
);
  localparam int LW   = $clog2(DATA_W);
  localparam int DIVW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [LW-1:0] LEN_FLOOR = LW'(MIN_LEN - 1);

  logic te, re, srst;
  logic [LW-1:0] len_m1, flen_m1, bit_q;
  logic [DATA_W-1:0] tdr, rdr, sr;
  logic tdre, tend, rdrf, orer;
  logic busy, tail, sck_q, sdo_q;
  logic [DIVW-1:0] div_q;

  wire wr_ctrl = bus_wr && bus_addr == 2'd0;
  wire wr_len  = bus_wr && bus_addr == 2'd1;
  wire wr_tdr  = bus_wr && bus_addr == 2'd2;
  wire wr_clr  = bus_wr && bus_addr == 2'd3;
  wire rd_rdr  = bus_rd && bus_addr == 2'd3;

  wire tick      = busy && div_q == DIVW'(HALF_DIV - 1);
  wire last_rise = tick && !tail && !sck_q && bit_q == flen_m1;
  wire frame_end = tick && tail;
  wire start     = !busy && !srst && (te ? (!tdre && !(re && orer)) : (re && !orer));

  wire [DATA_W-1:0] sr_next = {sr[DATA_W-2:0], sdi_i};
  wire [LW:0]       flen    = {1'b0, flen_m1} + (LW+1)'(1);
  wire [DATA_W:0]   hi_mask = {(DATA_W+1){1'b1}} << flen;
  wire [DATA_W-1:0] rx_word = sr_next & ~hi_mask[DATA_W-1:0];
  wire [DATA_W-1:0] tx_load = tdr << (LW'(DATA_W - 1) - len_m1);

  assign sck_o = sck_q;
  assign sdo_o = sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      te <= 1'b0; re <= 1'b0; srst <= 1'b0;
      len_m1 <= LEN_FLOOR;
    end else begin
      if (wr_ctrl) begin
        te   <= bus_wdata[0];
        re   <= bus_wdata[1];
        srst <= bus_wdata[2];
      end
      if (wr_len)
        len_m1 <= (bus_wdata[LW-1:0] < LEN_FLOOR) ? LEN_FLOOR : bus_wdata[LW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; tail <= 1'b0; sck_q <= 1'b1; sdo_q <= 1'b1;
      div_q <= '0; bit_q <= '0; sr <= '0; flen_m1 <= LEN_FLOOR;
    end else if (srst) begin
      busy <= 1'b0; tail <= 1'b0; sck_q <= 1'b1; sdo_q <= 1'b1;
      div_q <= '0; bit_q <= '0; sr <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      tail    <= 1'b0;
      sck_q   <= 1'b0;
      div_q   <= '0;
      bit_q   <= '0;
      flen_m1 <= len_m1;
      sr      <= te ? tx_load : '1;
      sdo_q   <= te ? tx_load[DATA_W-1] : 1'b1;
    end else if (busy) begin
      if (!tick) begin
        div_q <= div_q + DIVW'(1);
      end else begin
        div_q <= '0;
        if (tail) begin
          busy  <= 1'b0;
          tail  <= 1'b0;
          sdo_q <= 1'b1;
        end else if (!sck_q) begin
          sck_q <= 1'b1;
          sr    <= sr_next;
          if (bit_q == flen_m1) tail <= 1'b1;
          else bit_q <= bit_q + LW'(1);
        end else begin
          sck_q <= 1'b0;
          sdo_q <= sr[DATA_W-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdr <= '0; rdr <= '0;
      tdre <= 1'b1; tend <= 1'b1; rdrf <= 1'b0; orer <= 1'b0;
    end else begin
      if (start && te) tdre <= 1'b1;
      if (frame_end && te && tdre) tend <= 1'b1;
      if (wr_tdr) begin
        tdr  <= bus_wdata;
        tdre <= 1'b0;
        tend <= 1'b0;
      end
      if (rd_rdr) rdrf <= 1'b0;
      if (wr_clr && bus_wdata[0]) orer <= 1'b0;
      if (last_rise && re) begin
        if (rdrf && !rd_rdr) begin
          orer <= 1'b1;
        end else begin
          rdr  <= rx_word;
          rdrf <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = DATA_W'({srst, re, te});
      2'd1:    bus_rdata = DATA_W'(len_m1);
      2'd2:    bus_rdata = DATA_W'({orer, rdrf, tend, tdre});
      default: bus_rdata = rdr;
    endcase
  end

  AST_TEND_NEEDS_TDRE: assert property (@(posedge clk) disable iff (!rst_n) tend |-> tdre); // R5
  AST_SCK_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> sck_o); // R3
  AST_OVR_KEEPS_RDR: assert property (@(posedge clk) disable iff (!rst_n) $rose(orer) |-> $stable(rdr)); // R7
  AST_NO_RUN_AFTER_OVR: assert property (@(posedge clk) disable iff (!rst_n) (!busy && orer && re) |=> !busy); // R8
  AST_SRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n) srst |=> (!busy && sck_o)); // R11
  AST_WR_CLEARS_TEND: assert property (@(posedge clk) disable iff (!rst_n) wr_tdr |=> (!tend && !tdre)); // R4
  AST_BIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy |-> bit_q <= flen_m1); // R2
endmodule

// File: tb/sync_serial_master_tb_top.sv
`timescale 1ns/1ps
module sync_serial_master_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic sck_o, sdo_o, sdi_i;

  int checks = 0, errors = 0, pulses = 0;
  bit done = 1'b0;
  realtime t_fall = 0, t_rise = 0;

  logic [15:0] slv = '0, slv_pat = '0;
  logic slv_ld = 1'b0;

  always #2 clk = ~clk;

  sync_serial_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_o(sck_o), .sdo_o(sdo_o), .sdi_i(sdi_i)
  );

  assign sdi_i = slv[15];
  always @(posedge sck_o or posedge slv_ld)
    if (slv_ld) slv <= slv_pat;
    else slv <= {slv[14:0], sdo_o};
  always @(negedge sck_o) begin pulses++; t_fall = $realtime; end
  always @(posedge sck_o) t_rise = $realtime;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic pop(output logic [15:0] d);
    @(negedge clk); bus_addr = 2'd3; bus_rd = 1'b1; #0.5; d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_flag(input int idx, input logic val, input string req);
    logic [15:0] s;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk); peek(2'd2, s);
      if (s[idx] === val) return;
    end
    chk(req, 32'hDEAD, {31'd0, val});
  endtask

  task automatic load_slave(input logic [15:0] p);
    slv_pat = p; slv_ld = 1'b1; #0.5; slv_ld = 1'b0;
  endtask

  task automatic srst_pulse;
    wr(2'd0, 16'h4); wr(2'd0, 16'h0);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    peek(2'd2, d); chk("R1 status", d, 16'h3);
    peek(2'd0, d); chk("R1 ctrl", d, 16'h0);
    peek(2'd1, d); chk("R1 len", d, 16'h7);
    chk("R1 sck", sck_o, 1); chk("R1 sdo", sdo_o, 1);
  endtask

  task automatic t_len;
    logic [15:0] d;
    wr(2'd1, 16'h3); peek(2'd1, d); chk("R2 clamp", d, 16'h7);
    wr(2'd1, 16'hF); peek(2'd1, d); chk("R2 max", d, 16'hF);
    wr(2'd1, 16'h7);
  endtask

  task automatic t_tx;
    logic [15:0] d;
    wr(2'd0, 16'h1); pulses = 0;
    wr(2'd2, 16'h00A5);
    peek(2'd2, d); chk("R4 write clears empty/end", d[1:0], 2'b00);
    wait_flag(1, 1'b1, "R5 tend");
    idle(4);
    chk("R3 msb-first data", slv[7:0], 8'hA5);
    chk("R2 pulses 8", pulses, 8);
    chk("R3 half period", int'(t_rise - t_fall), HALF_NS);
    peek(2'd2, d); chk("R4 empty after load", d[3:0], 4'b0011);
  endtask

  task automatic t_tx_b2b;
    logic [15:0] d;
    wr(2'd1, 16'd11); pulses = 0;
    wr(2'd2, 16'h0ABC);
    wait_flag(0, 1'b1, "R4 load sets empty");
    wr(2'd2, 16'h0123);
    wait_flag(1, 1'b1, "R5 tend b2b");
    idle(4);
    chk("R5 back-to-back pulses", pulses, 24);
    chk("R5 second word", slv[11:0], 12'h123);
    wr(2'd0, 16'h0); wr(2'd1, 16'h7);
  endtask

  task automatic t_rx;
    logic [15:0] d;
    wr(2'd1, 16'd9); srst_pulse();
    load_slave(16'h2C5 << 6); pulses = 0;
    wr(2'd0, 16'h2);
    wait_flag(2, 1'b1, "R6 rdrf");
    peek(2'd3, d); chk("R6 received word", d, 16'h2C5);
    wait_flag(3, 1'b1, "R9 overrun on second frame");
    idle(40);
    chk("R9 two frames then halt", pulses, 20);
    peek(2'd3, d); chk("R7 rdr kept", d, 16'h2C5);
    wr(2'd0, 16'h0);
    pop(d); peek(2'd2, d); chk("R6 read clears rdrf", d[2], 0);
    wr(2'd3, 16'h1); peek(2'd2, d); chk("R7 clear overrun", d[3], 0);
    wr(2'd1, 16'h7);
  endtask

  task automatic t_duplex;
    logic [15:0] d;
    srst_pulse(); wr(2'd0, 16'h3);
    load_slave(16'h3C00); pulses = 0;
    idle(20); chk("R8 no start without write", pulses, 0);
    wr(2'd2, 16'h0096);
    wait_flag(1, 1'b1, "R8 tend");
    idle(30);
    peek(2'd3, d); chk("R8 duplex rx", d, 16'h3C);
    chk("R8 duplex tx", slv[7:0], 8'h96);
    chk("R8 single frame", pulses, 8);
    peek(2'd2, d); chk("R6 rdrf set", d[2], 1);
  endtask

  task automatic t_duplex_ovr;
    logic [15:0] d;
    pulses = 0;
    wr(2'd2, 16'h0011);
    wait_flag(0, 1'b1, "R8 first load");
    wr(2'd2, 16'h0022);
    wait_flag(3, 1'b1, "R7 duplex overrun");
    idle(40);
    chk("R8 halt on overrun", pulses, 8);
    peek(2'd2, d); chk("R8 word still waiting", d[1:0], 2'b00);
    peek(2'd3, d); chk("R7 rdr unchanged", d, 16'h3C);
    wr(2'd0, 16'h0); pop(d); wr(2'd3, 16'h1);
    wr(2'd0, 16'h3);
    wait_flag(1, 1'b1, "R8 pending sent");
    idle(8); pop(d);
  endtask

  task automatic t_exit;
    logic [15:0] d;
    pulses = 0;
    wr(2'd0, 16'h1); idle(3); wr(2'd0, 16'h0); idle(40);
    chk("R10 re-first no clock", pulses, 0);
    wr(2'd0, 16'h3); wr(2'd0, 16'h0); idle(40);
    chk("R10 both-together no clock", pulses, 0);
    wr(2'd0, 16'h3); wr(2'd0, 16'h2); idle(40);
    chk("R10 te-first gives clock", pulses > 0, 1);
    wr(2'd0, 16'h0); idle(80);
    pop(d); wr(2'd3, 16'h1);
  endtask

  task automatic t_srst;
    logic [15:0] d, r0;
    int p;
    peek(2'd3, r0);
    wr(2'd1, 16'hF); wr(2'd0, 16'h1); pulses = 0;
    wr(2'd2, 16'hF0F0); idle(10);
    chk("R11 frame running", pulses > 0, 1);
    wr(2'd0, 16'h5); p = pulses; idle(40);
    chk("R11 clock stopped", pulses, p);
    chk("R11 sck high", sck_o, 1);
    peek(2'd3, d); chk("R11 rdr kept", d, r0);
    peek(2'd1, d); chk("R11 len kept", d, 16'hF);
    peek(2'd0, d); chk("R11 enables kept", d, 16'h5);
    peek(2'd2, d); chk("R11 flags kept", d[1:0], 2'b01);
    wr(2'd0, 16'h0);
  endtask

  localparam int HALF_NS = 8;

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1'b1; idle(2);
    t_reset();
    t_len();
    t_tx();
    t_tx_b2b();
    t_rx();
    t_duplex();
    t_duplex_ovr();
    t_exit();
    t_srst();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule